// File: doc/BRIEF.md
# Core Supply Level Stepping Sequencer

This controller walks a 2-bit core-supply level code toward a target that software requests. It never moves more than one level at a time. Around every regulator step it updates two threshold codes in a fixed order: one for a low-side voltage monitor and one for a low-side supervisor. The order for raising the level differs from the order for lowering it, so the supervisor never watches for a voltage that the regulator has not yet produced. An external regulator model acknowledges each upward step through a "level reached" flag. If that flag stays low for longer than a programmable wait, the step is abandoned.

Software uses one 16-bit control register, written a byte at a time. The high byte holds a key: one value opens the register and another closes it. The low byte carries the requested level, two enables and an interrupt-clear bit. A low-byte write made while the register is closed changes nothing and leaves a sticky violation flag. The block also conditions three comparator flags into a sticky monitor interrupt and a reset request. Brownout always reaches the reset request.

Top module: `core_level_seq`

## Requirements
- R1: After reset the level code and both threshold codes are 0, busy, error, key violation and the monitor interrupt are 0, the register is locked, and both enables are set. The level code is 2 bits, covering four levels from 0 to 3.
- R2: A high-byte write (`wr_sel`=1) of 0xA5 unlocks the register and a high-byte write of 0x00 locks it. Any other high-byte value leaves the lock state unchanged. A low-byte write (`wr_sel`=0) made while locked has no effect at all and sets `key_viol`, which stays set until reset.
- R3: The level code changes by exactly one per move. A target two or three levels away is reached by passing through every intermediate level.
- R4: Each upward step first sets the monitor threshold to the new level. The level code is raised on a later cycle, while the supervisor threshold keeps the old level. The supervisor threshold is raised to the new level only after `vreg_ready` has been seen high.
- R5: Each downward step first sets both thresholds to the lower level. The level code is lowered on a later cycle.
- R6: During an upward step the controller waits for `vreg_ready`. A regulator delay of up to `settle_limit` cycles completes the step. If `vreg_ready` is still low after `settle_limit`+1 wait cycles, the step is abandoned: the level code and the monitor threshold return to the last level both thresholds agreed on, `error` is set, and busy clears. Accepting a new target clears `error`.
- R7: An unlocked low-byte write whose bits [1:0] differ from the current level starts a sequence and raises `busy`. `busy` stays high until the last update of that sequence. Low-byte writes while busy do not change the target. A requested level equal to the current level starts nothing.
- R8: An unlocked low-byte write sets the monitor enable from bit 4 and clears `mon_irq` when bit 7 is 1. While the monitor is enabled, `mon_low` sets `mon_irq`, which stays set after `mon_low` falls. While the monitor is disabled, `mon_low` is ignored.
- R9: An unlocked low-byte write sets the supervisor enable from bit 5. `por_req` is high one cycle after `sup_low` is seen with the supervisor enabled, or after `bor_low` is seen, whether or not the supervisor is enabled. `sup_low` alone has no effect while the supervisor is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_sel | input | 1 | 1 selects the key (high) byte, 0 the control (low) byte |
| wr_data | input | 8 | Byte written |
| settle_limit | input | 16 | Allowed wait for the regulator acknowledge, in cycles |
| vreg_ready | input | 1 | Regulator reports the commanded level is reached |
| mon_low | input | 1 | Low-side monitor comparator flag |
| sup_low | input | 1 | Low-side supervisor comparator flag |
| bor_low | input | 1 | Brownout detector flag |
| vreg_level | output | 2 | Level code to the regulator |
| mon_thr | output | 2 | Monitor threshold code |
| sup_thr | output | 2 | Supervisor threshold code |
| busy | output | 1 | Sequence in progress |
| error | output | 1 | Last upward step timed out |
| mon_irq | output | 1 | Sticky monitor interrupt |
| por_req | output | 1 | Reset request |
| key_viol | output | 1 | Sticky locked-write flag |

## Verification
The hardest case to reach is the settle-timeout edge. It needs a regulator delay exactly equal to the allowed wait, or one cycle longer, part-way through a multi-level climb. The bench contains a regulator model whose acknowledge delay is set per vector, so the delay can be set on each side of `settle_limit`, including a zero limit. A negedge monitor follows every level and threshold change during each sequence. It checks the order of the updates, not only the final state. A write made while a sequence is running is timed from the busy flag.

// File: rtl/cls_pkg.sv
package cls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP_MON,
        ST_UP_REG,
        ST_UP_WAIT,
        ST_UP_SUP,
        ST_DN_THR,
        ST_DN_REG
    } step_state_e;

    localparam logic [7:0] KEY_OPEN  = 8'hA5;
    localparam logic [7:0] KEY_CLOSE = 8'h00;

    localparam int CFG_MON_EN_BIT = 4;
    localparam int CFG_SUP_EN_BIT = 5;
    localparam int CFG_CLR_BIT    = 7;

endpackage

// File: rtl/cls_keygate.sv
module cls_keygate
    import cls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       cfg_wr,
    output logic       key_viol
);

    typedef struct packed {
        logic unl;
        logic viol;
    } gate_t;

    gate_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        cfg_wr = wr_en && !wr_sel && s_q.unl;
        if (wr_en && wr_sel) begin
            if (wr_data == KEY_OPEN)
                s_d.unl = 1'b1;
            else if (wr_data == KEY_CLOSE)
                s_d.unl = 1'b0;
        end
        if (wr_en && !wr_sel && !s_q.unl)
            s_d.viol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign key_viol = s_q.viol;

    p_locked_write_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !s_q.unl) |=> key_viol);
    p_viol_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_viol |=> key_viol);
    p_locked_no_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.unl |-> !cfg_wr);

endmodule

// File: rtl/cls_stepper.sv
module cls_stepper
    import cls_pkg::*;
#(
    parameter int LVL_W    = 2,
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [LVL_W-1:0]    req_lvl,
    input  logic [SETTLE_W-1:0] settle_limit,
    input  logic                vreg_ready,
    output logic [LVL_W-1:0]    vreg_level,
    output logic [LVL_W-1:0]    mon_thr,
    output logic [LVL_W-1:0]    sup_thr,
    output logic                busy,
    output logic                error
);

    localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

    typedef struct packed {
        step_state_e         st;
        logic [LVL_W-1:0]    lvl;
        logic [LVL_W-1:0]    mon;
        logic [LVL_W-1:0]    sup;
        logic [LVL_W-1:0]    tgt;
        logic [SETTLE_W-1:0] cnt;
        logic                busy;
        logic                err;
    } step_t;

    step_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req && req_lvl != s_q.lvl) begin
                    s_d.tgt  = req_lvl;
                    s_d.busy = 1'b1;
                    s_d.err  = 1'b0;
                    s_d.st   = (req_lvl > s_q.lvl) ? ST_UP_MON : ST_DN_THR;
                end
            end
            ST_UP_MON: begin
                s_d.mon = s_q.lvl + ONE;
                s_d.st  = ST_UP_REG;
            end
            ST_UP_REG: begin
                s_d.lvl = s_q.lvl + ONE;
                s_d.cnt = '0;
                s_d.st  = ST_UP_WAIT;
            end
            ST_UP_WAIT: begin
                if (vreg_ready) begin
                    s_d.st = ST_UP_SUP;
                end else if (s_q.cnt == settle_limit) begin
                    s_d.lvl  = s_q.sup;
                    s_d.mon  = s_q.sup;
                    s_d.err  = 1'b1;
                    s_d.busy = 1'b0;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + SETTLE_W'(1);
                end
            end
            ST_UP_SUP: begin
                s_d.sup = s_q.lvl;
                if (s_q.lvl == s_q.tgt) begin
                    s_d.busy = 1'b0;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.st = ST_UP_MON;
                end
            end
            ST_DN_THR: begin
                s_d.mon = s_q.lvl - ONE;
                s_d.sup = s_q.lvl - ONE;
                s_d.st  = ST_DN_REG;
            end
            ST_DN_REG: begin
                s_d.lvl = s_q.lvl - ONE;
                if (s_q.lvl - ONE == s_q.tgt) begin
                    s_d.busy = 1'b0;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.st = ST_DN_THR;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign vreg_level = s_q.lvl;
    assign mon_thr    = s_q.mon;
    assign sup_thr    = s_q.sup;
    assign busy       = s_q.busy;
    assign error      = s_q.err;

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_level != $past(vreg_level)) |->
        (({1'b0, vreg_level} == {1'b0, $past(vreg_level)} + 1'b1) ||
         ({1'b0, vreg_level} + 1'b1 == {1'b0, $past(vreg_level)})));
    p_mon_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_level > $past(vreg_level)) |->
        (mon_thr == vreg_level && sup_thr == $past(vreg_level)));
    p_sup_after_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_thr > $past(sup_thr)) |-> ($past(vreg_ready, 2) && sup_thr == vreg_level));
    p_thr_before_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_level < $past(vreg_level)) |-> (mon_thr == vreg_level && sup_thr == vreg_level));
    p_sup_not_above_mon_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sup_thr <= mon_thr);
    p_timeout_sets_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> (!busy && vreg_level == sup_thr));
    p_idle_level_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req) |=> $stable(vreg_level));

endmodule

// File: rtl/cls_alarms.sv
module cls_alarms
    import cls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_mon_en,
    input  logic cfg_sup_en,
    input  logic cfg_clr,
    input  logic mon_low,
    input  logic sup_low,
    input  logic bor_low,
    output logic mon_irq,
    output logic por_req
);

    typedef struct packed {
        logic mon_en;
        logic sup_en;
        logic irq;
        logic por;
    } alarm_t;

    alarm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_wr) begin
            s_d.mon_en = cfg_mon_en;
            s_d.sup_en = cfg_sup_en;
            if (cfg_clr)
                s_d.irq = 1'b0;
        end
        if (s_q.mon_en && mon_low)
            s_d.irq = 1'b1;
        s_d.por = (s_q.sup_en && sup_low) || bor_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.mon_en <= 1'b1;
            s_q.sup_en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mon_irq = s_q.irq;
    assign por_req = s_q.por;

    p_brownout_always_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bor_low |=> por_req);
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_irq && !(cfg_wr && cfg_clr)) |=> mon_irq);
    p_por_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_req) |-> ($past(bor_low) || $past(sup_low)));

endmodule

// File: rtl/core_level_seq.sv
module core_level_seq
    import cls_pkg::*;
#(
    parameter int LVL_W    = 2,
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [7:0]          wr_data,
    input  logic [SETTLE_W-1:0] settle_limit,
    input  logic                vreg_ready,
    input  logic                mon_low,
    input  logic                sup_low,
    input  logic                bor_low,
    output logic [LVL_W-1:0]    vreg_level,
    output logic [LVL_W-1:0]    mon_thr,
    output logic [LVL_W-1:0]    sup_thr,
    output logic                busy,
    output logic                error,
    output logic                mon_irq,
    output logic                por_req,
    output logic                key_viol
);

    logic cfg_wr;
    logic unused_bits;

    assign unused_bits = ^{wr_data[6], wr_data[3:LVL_W]};

    cls_keygate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cfg_wr   (cfg_wr),
        .key_viol (key_viol)
    );

    cls_stepper #(
        .LVL_W    (LVL_W),
        .SETTLE_W (SETTLE_W)
    ) u_step (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (cfg_wr),
        .req_lvl      (wr_data[LVL_W-1:0]),
        .settle_limit (settle_limit),
        .vreg_ready   (vreg_ready),
        .vreg_level   (vreg_level),
        .mon_thr      (mon_thr),
        .sup_thr      (sup_thr),
        .busy         (busy),
        .error        (error)
    );

    cls_alarms u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_mon_en (wr_data[CFG_MON_EN_BIT]),
        .cfg_sup_en (wr_data[CFG_SUP_EN_BIT]),
        .cfg_clr    (wr_data[CFG_CLR_BIT]),
        .mon_low    (mon_low),
        .sup_low    (sup_low),
        .bor_low    (bor_low),
        .mon_irq    (mon_irq),
        .por_req    (por_req)
    );

endmodule

// File: tb/core_level_seq_test.sv
module core_level_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] settle_limit = 16'd10;
    logic        vreg_ready;
    logic        mon_low = 1'b0, sup_low = 1'b0, bor_low = 1'b0;
    logic [1:0]  vreg_level, mon_thr, sup_thr;
    logic        busy, error, mon_irq, por_req, key_viol;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int mdly = 0;
    int mcnt = 0;
    logic [1:0] mprev = 2'd0;

    always #2 clk = ~clk;

    core_level_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .settle_limit(settle_limit), .vreg_ready(vreg_ready), .mon_low(mon_low),
        .sup_low(sup_low), .bor_low(bor_low), .vreg_level(vreg_level), .mon_thr(mon_thr),
        .sup_thr(sup_thr), .busy(busy), .error(error), .mon_irq(mon_irq),
        .por_req(por_req), .key_viol(key_viol)
    );

    // regulator model: ready once mdly negedges have passed since the last level change
    always @(negedge clk) begin
        if (!rst_n) begin
            mprev      <= 2'd0;
            mcnt       <= 0;
            vreg_ready <= 1'b0;
        end else if (vreg_level != mprev) begin
            mprev      <= vreg_level;
            mcnt       <= 0;
            vreg_ready <= (mdly == 0);
        end else begin
            if (mcnt < 1000) mcnt <= mcnt + 1;
            vreg_ready <= (mcnt + 1 >= mdly);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ordering monitor
    logic [1:0] p_lvl = 2'd0, p_sup = 2'd0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (vreg_level > p_lvl) begin
                chk("R3 up by one", int'(vreg_level) - int'(p_lvl), 1);
                chk("R4 monitor raised with level", mon_thr, vreg_level);
                chk("R4 supervisor still at old level", sup_thr, p_lvl);
            end
            if (vreg_level < p_lvl) begin
                chk("R3 down by one", int'(p_lvl) - int'(vreg_level), 1);
                chk("R5 thresholds lowered before level", {mon_thr, sup_thr}, {vreg_level, vreg_level});
            end
            if (sup_thr > p_sup) begin
                chk("R4 supervisor raised to level", sup_thr, vreg_level);
                chk("R4 supervisor raised after ready", vreg_ready, 1);
            end
            p_lvl <= vreg_level;
            p_sup <= sup_thr;
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  tgt;
        logic [7:0]  dly;
        logic [15:0] lim;
        logic [1:0]  lvl;
        logic        err;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{2'd1, 8'd2, 16'd10, 2'd1, 1'b0},
        '{2'd3, 8'd3, 16'd10, 2'd3, 1'b0},
        '{2'd0, 8'd0, 16'd10, 2'd0, 1'b0},
        '{2'd2, 8'd5, 16'd5,  2'd2, 1'b0},
        '{2'd3, 8'd6, 16'd5,  2'd2, 1'b1},
        '{2'd3, 8'd1, 16'd5,  2'd3, 1'b0},
        '{2'd3, 8'd1, 16'd5,  2'd3, 1'b0},
        '{2'd1, 8'd0, 16'd5,  2'd1, 1'b0},
        '{2'd0, 8'd0, 16'd0,  2'd0, 1'b0},
        '{2'd2, 8'd0, 16'd0,  2'd2, 1'b0},
        '{2'd3, 8'd1, 16'd0,  2'd2, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", vreg_level, 0);
        chk("R1 thresholds", {mon_thr, sup_thr}, 0);
        chk("R1 busy/error", {busy, error}, 0);
        chk("R1 irq/por/viol", {mon_irq, por_req, key_viol}, 0);

        wr(1'b1, 8'hA5);
        for (int v = 0; v < 11; v++) begin
            mdly = int'(VECS[v].dly);
            settle_limit = VECS[v].lim;
            wr(1'b0, 8'h30 | {6'd0, VECS[v].tgt});
            if (VECS[v].tgt != VECS[(v == 0) ? 0 : v - 1].lvl || v == 0)
                chk("R7 busy on accept", busy, 1);
            else
                chk("R7 same level starts nothing", busy, 0);
            wait_idle();
            chk("R3 final level", vreg_level, VECS[v].lvl);
            chk("R6 error status", error, VECS[v].err);
            chk("R6 thresholds at kept level", {mon_thr, sup_thr}, {VECS[v].lvl, VECS[v].lvl});
            chk("R7 busy clear", busy, 0);
        end

        // R7 write while busy is ignored (level 2 -> 3, then request 0 mid-way)
        mdly = 4; settle_limit = 16'd10;
        wr(1'b0, 8'h33);
        wr(1'b0, 8'h30);
        wait_idle();
        chk("R7 busy write ignored", vreg_level, 3);

        // R8 monitor interrupt
        @(negedge clk); mon_low = 1'b1;
        @(negedge clk); mon_low = 1'b0;
        @(negedge clk);
        chk("R8 irq sticky", mon_irq, 1);
        wr(1'b0, 8'hB3);
        chk("R8 irq cleared", mon_irq, 0);
        wr(1'b0, 8'h23);
        @(negedge clk); mon_low = 1'b1;
        @(negedge clk); mon_low = 1'b0;
        @(negedge clk);
        chk("R8 disabled monitor ignored", mon_irq, 0);

        // R9 supervisor and brownout
        wr(1'b0, 8'h03);
        @(negedge clk); bor_low = 1'b1;
        @(negedge clk);
        chk("R9 brownout with supervisor off", por_req, 1);
        bor_low = 1'b0;
        @(negedge clk);
        chk("R9 por released", por_req, 0);
        sup_low = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 disabled supervisor ignored", por_req, 0);
        sup_low = 1'b0;
        wr(1'b0, 8'h23);
        sup_low = 1'b1;
        @(negedge clk);
        chk("R9 supervisor reset request", por_req, 1);
        sup_low = 1'b0;
        @(negedge clk);

        // R2 lock, bad key, locked write
        chk("R2 no violation yet", key_viol, 0);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h30);
        @(negedge clk);
        chk("R2 locked write flagged", key_viol, 1);
        chk("R2 locked write discarded", {busy, vreg_level}, {1'b0, 2'd3});
        wr(1'b1, 8'h5A);
        wr(1'b0, 8'h31);
        @(negedge clk);
        chk("R2 bad key keeps lock", {busy, vreg_level}, {1'b0, 2'd3});
        chk("R2 violation sticky", key_viol, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk("watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule